// File: doc/BRIEF.md
# Hamming Single-Error Corrector with Encoder

The block pairs a Hamming encoder with a syndrome-based corrector. The encode path places seven data bits into an eleven-bit frame. Check bits sit at the frame positions whose index is a power of two, and each check bit sets even parity over its coverage group. The decode path takes a received frame and derives a four-bit syndrome. From the syndrome it classifies the frame and repairs a single flipped data bit. It returns the recovered data, the syndrome and a two-bit status.

Both paths are registered, with one valid strobe in and one valid strobe out. The two paths are independent, so a link endpoint can encode outgoing words and check incoming ones in the same cycle. The data width is a parameter. The number of check bits and the frame width are derived from it.

Top module: `hamm_codec`

## Requirements
- R1: Frame positions are numbered 1 to 11, and position p is carried on frame bit p-1. Each check bit at position 2^j (j = 0..3) makes the XOR of all frame positions whose index has bit j set equal to zero.
- R2: Data bit i (0 = least significant) is placed at the i-th non-power-of-two position in ascending order. This maps data bits 0..6 onto positions 3, 5, 6, 7, 9, 10, 11. Data 7'b1001101 encodes to 11'b10011100101 (position 11 on the left).
- R3: `enc_valid_o` rises in the cycle after `enc_valid_i` is sampled high and is low after a cycle with `enc_valid_i` low. `enc_frame_o` keeps its last value while no new word is accepted.
- R4: While `rst_ni` is low, both valid outputs are low and every data, frame, syndrome and status output is zero.
- R5: `dec_syndrome_o` bit j is the XOR of the received positions whose index has bit j set. Equivalently, it is the XOR of the indices of all set positions.
- R6: A zero syndrome gives status 0 (clean), and the data is taken unchanged from the data positions.
- R7: A syndrome with exactly one bit set names a check position. It gives status 1 (check bit hit), and the data is taken unchanged.
- R8: A syndrome with two or more bits set and a value of 11 or less gives status 2 (data repaired). The named position is inverted before the data is extracted. For example, flipping position 6 of 11'b10011100101 gives syndrome 4'b0110 and recovers data 7'b1001101.
- R9: A syndrome of 12 to 15 gives status 3 (uncorrectable), and the data is extracted from the frame unchanged.
- R10: `dec_valid_o` rises in the cycle after `dec_valid_i` is sampled high and is low otherwise. The decode outputs hold while no new frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Data word to encode is present |
| enc_data_i | input | 7 | Data word to encode |
| enc_valid_o | output | 1 | Encoded frame is valid |
| enc_frame_o | output | 11 | Encoded frame, bit p-1 = position p |
| dec_valid_i | input | 1 | Received frame is present |
| dec_frame_i | input | 11 | Received frame, bit p-1 = position p |
| dec_valid_o | output | 1 | Decode result is valid |
| dec_data_o | output | 7 | Recovered data word |
| dec_syndrome_o | output | 4 | Syndrome of the received frame |
| dec_status_o | output | 2 | 0 clean, 1 check bit hit, 2 data repaired, 3 uncorrectable |

## Verification
The encoder is driven with all 128 data words. Each frame is compared against a frame built in the bench from the index-XOR rule, which separates data placement faults from check-bit faults. The decoder is driven with all 2048 possible frames, which covers every syndrome value. These frames include every clean codeword, every single flip at a check position, every single flip at a data position, and the multi-bit patterns whose syndrome lands at 12 to 15. Each class is checked separately for syndrome, status and data. Idle cycles between bursts show that the valid strobes drop and the outputs hold.

// File: rtl/hamm_pkg.sv
package hamm_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_CHK_HIT  = 2'd1,
    ST_DATA_FIX = 2'd2,
    ST_UNCORR   = 2'd3
  } dec_status_e;

  function automatic bit is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // Smallest check count p with 2^p >= data + p + 1
  function automatic int unsigned chk_bits(int unsigned dw);
    int unsigned p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Position (1-based) of data bit idx
  function automatic int unsigned data_pos(int unsigned idx);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned p = 1; p < 64; p++) begin
      if (!is_pow2(p) && res == 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Frame bits covered by check bit j (bit p-1 = position p)
  function automatic logic [31:0] cover_mask(int unsigned j, int unsigned fw);
    logic [31:0] m;
    m = '0;
    for (int unsigned p = 1; p <= 32; p++)
      if (p <= fw && ((p >> j) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/hamm_enc.sv
module hamm_enc
  import hamm_pkg::*;
#(
  parameter int unsigned DATA_W = 7,
  localparam int unsigned P_W = chk_bits(DATA_W),
  localparam int unsigned F_W = DATA_W + P_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [F_W-1:0]    frame_o
);

  logic [31:0] mask;

  always_comb begin
    frame_o = '0;
    mask    = '0;
    for (int unsigned i = 0; i < DATA_W; i++)
      frame_o[data_pos(i)-1] = data_i[i];
    // check positions are still zero here, so each group XOR sees data only
    for (int unsigned j = 0; j < P_W; j++) begin
      mask = cover_mask(j, F_W);
      frame_o[(1 << j)-1] = ^(frame_o & mask[F_W-1:0]);
    end
  end

endmodule

// File: rtl/hamm_syn.sv
module hamm_syn
  import hamm_pkg::*;
#(
  parameter int unsigned DATA_W = 7,
  localparam int unsigned P_W = chk_bits(DATA_W),
  localparam int unsigned F_W = DATA_W + P_W
) (
  input  logic [F_W-1:0] frame_i,
  output logic [P_W-1:0] syn_o
);

  for (genvar j = 0; j < P_W; j++) begin : g_grp
    localparam logic [31:0] MASK = cover_mask(j, F_W);
    assign syn_o[j] = ^(frame_i & MASK[F_W-1:0]);
  end

endmodule

// File: rtl/hamm_fix.sv
module hamm_fix
  import hamm_pkg::*;
#(
  parameter int unsigned DATA_W = 7,
  localparam int unsigned P_W = chk_bits(DATA_W),
  localparam int unsigned F_W = DATA_W + P_W
) (
  input  logic [F_W-1:0]    frame_i,
  input  logic [P_W-1:0]    syn_i,
  output logic [DATA_W-1:0] data_o,
  output dec_status_e       status_o
);

  localparam logic [P_W-1:0] LAST_POS = P_W'(F_W);

  logic [F_W-1:0] fixed;

  always_comb begin
    fixed    = frame_i;
    status_o = ST_CLEAN;
    if (syn_i == '0) begin
      status_o = ST_CLEAN;
    end else if ($countones(syn_i) == 1) begin
      status_o = ST_CHK_HIT;
    end else if (syn_i > LAST_POS) begin
      status_o = ST_UNCORR;
    end else begin
      status_o = ST_DATA_FIX;
      for (int unsigned p = 0; p < F_W; p++)
        if (syn_i == P_W'(p + 1)) fixed[p] = ~frame_i[p];
    end
  end

  always_comb begin
    data_o = '0;
    for (int unsigned i = 0; i < DATA_W; i++)
      data_o[i] = fixed[data_pos(i)-1];
  end

endmodule

// File: rtl/hamm_codec.sv
module hamm_codec
  import hamm_pkg::*;
#(
  parameter int unsigned DATA_W = 7,
  localparam int unsigned P_W = chk_bits(DATA_W),
  localparam int unsigned F_W = DATA_W + P_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [F_W-1:0]    enc_frame_o,
  input  logic              dec_valid_i,
  input  logic [F_W-1:0]    dec_frame_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [P_W-1:0]    dec_syndrome_o,
  output logic [1:0]        dec_status_o
);

  localparam logic [P_W-1:0] LAST_POS = P_W'(F_W);

  // Encode path
  logic [F_W-1:0] enc_frame_c;

  hamm_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i  (enc_data_i),
    .frame_o (enc_frame_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_frame_o <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_frame_o <= enc_frame_c;
    end
  end

  // Decode path
  logic [P_W-1:0]    syn_c;
  logic [DATA_W-1:0] data_c;
  dec_status_e       status_c;

  hamm_syn #(.DATA_W(DATA_W)) u_syn (
    .frame_i (dec_frame_i),
    .syn_o   (syn_c)
  );

  hamm_fix #(.DATA_W(DATA_W)) u_fix (
    .frame_i  (dec_frame_i),
    .syn_i    (syn_c),
    .data_o   (data_c),
    .status_o (status_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o    <= 1'b0;
      dec_data_o     <= '0;
      dec_syndrome_o <= '0;
      dec_status_o   <= '0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_data_o     <= data_c;
        dec_syndrome_o <= syn_c;
        dec_status_o   <= status_c;
      end
    end
  end

  // R3
  enc_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o);
  // R3
  enc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> !enc_valid_o && $stable(enc_frame_o));
  // R2
  enc_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> (enc_frame_o[data_pos(0)-1] == $past(enc_data_i[0])) &&
                    (enc_frame_o[data_pos(DATA_W-1)-1] == $past(enc_data_i[DATA_W-1])));
  // R10
  dec_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);
  // R10
  dec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> !dec_valid_o && $stable(dec_data_o) && $stable(dec_status_o));
  // R6
  clean_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_status_o == ST_CLEAN) |-> dec_syndrome_o == '0);
  // R7
  chk_hit_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_status_o == ST_CHK_HIT) |-> $countones(dec_syndrome_o) == 1);
  // R8
  data_fix_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_status_o == ST_DATA_FIX) |->
      ($countones(dec_syndrome_o) > 1) && (dec_syndrome_o <= LAST_POS));
  // R9
  uncorr_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_status_o == ST_UNCORR) |-> dec_syndrome_o > LAST_POS);

endmodule

// File: tb/hamm_codec_tb.sv
`timescale 1ns/1ps
module hamm_codec_tb;

  localparam int DW = 7;
  localparam int FW = 11;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enc_valid_i = 1'b0;
  logic [DW-1:0] enc_data_i = '0;
  logic          enc_valid_o;
  logic [FW-1:0] enc_frame_o;
  logic          dec_valid_i = 1'b0;
  logic [FW-1:0] dec_frame_i = '0;
  logic          dec_valid_o;
  logic [DW-1:0] dec_data_o;
  logic [PW-1:0] dec_syndrome_o;
  logic [1:0]    dec_status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  hamm_codec u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .enc_valid_i    (enc_valid_i),
    .enc_data_i     (enc_data_i),
    .enc_valid_o    (enc_valid_o),
    .enc_frame_o    (enc_frame_o),
    .dec_valid_i    (dec_valid_i),
    .dec_frame_i    (dec_frame_i),
    .dec_valid_o    (dec_valid_o),
    .dec_data_o     (dec_data_o),
    .dec_syndrome_o (dec_syndrome_o),
    .dec_status_o   (dec_status_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit pw2(int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // XOR of indices of set positions
  function automatic int idx_xor(logic [FW-1:0] f);
    int s = 0;
    for (int p = 1; p <= FW; p++) if (f[p-1]) s ^= p;
    return s;
  endfunction

  function automatic logic [DW-1:0] pull_data(logic [FW-1:0] f);
    logic [DW-1:0] d = '0;
    int k = 0;
    for (int p = 1; p <= FW; p++) if (!pw2(p)) begin d[k] = f[p-1]; k++; end
    return d;
  endfunction

  function automatic logic [FW-1:0] build(logic [DW-1:0] d);
    logic [FW-1:0] f = '0;
    int k = 0;
    int s;
    for (int p = 1; p <= FW; p++) if (!pw2(p)) begin f[p-1] = d[k]; k++; end
    s = idx_xor(f);
    for (int j = 0; j < PW; j++) f[(1 << j)-1] = s[j];
    return f;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] ef;
    logic [FW-1:0] fx;
    int s;
    int est;
    logic [DW-1:0] ed;

    // R4 reset state
    repeat (3) @(negedge clk);
    check(enc_valid_o == 1'b0 && dec_valid_o == 1'b0, "R4 valids", {enc_valid_o, dec_valid_o}, 0);
    check(enc_frame_o == '0, "R4 frame", enc_frame_o, 0);
    check(dec_data_o == '0 && dec_syndrome_o == '0 && dec_status_o == '0, "R4 decode outputs",
          {dec_data_o, dec_syndrome_o, dec_status_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R1 worked example
    enc_valid_i = 1'b1; enc_data_i = 7'b1001101;
    @(negedge clk);
    enc_valid_i = 1'b0;
    check(enc_valid_o == 1'b1, "R3 enc valid", enc_valid_o, 1);
    check(enc_frame_o == 11'b10011100101, "R2 example frame", enc_frame_o, 11'b10011100101);
    @(negedge clk);
    check(enc_valid_o == 1'b0, "R3 enc idle", enc_valid_o, 0);
    check(enc_frame_o == 11'b10011100101, "R3 frame hold", enc_frame_o, 11'b10011100101);

    // R8 worked example: flip position 6
    dec_valid_i = 1'b1; dec_frame_i = 11'b10011100101 ^ 11'b00000100000;
    @(negedge clk);
    dec_valid_i = 1'b0;
    check(dec_valid_o == 1'b1, "R10 dec valid", dec_valid_o, 1);
    check(dec_syndrome_o == 4'b0110, "R8 example syndrome", dec_syndrome_o, 6);
    check(dec_status_o == 2'd2, "R8 example status", dec_status_o, 2);
    check(dec_data_o == 7'b1001101, "R8 example data", dec_data_o, 7'b1001101);
    @(negedge clk);
    check(dec_valid_o == 1'b0, "R10 dec idle", dec_valid_o, 0);
    check(dec_data_o == 7'b1001101 && dec_status_o == 2'd2, "R10 decode hold",
          {dec_data_o, dec_status_o}, {7'b1001101, 2'd2});

    // R1 R2 R3 exhaustive encode
    for (int d = 0; d < (1 << DW); d++) begin
      enc_valid_i = 1'b1; enc_data_i = DW'(d);
      @(negedge clk);
      ef = build(DW'(d));
      check(enc_valid_o == 1'b1, "R3 enc valid sweep", enc_valid_o, 1);
      check(enc_frame_o == ef, "R1 R2 frame", enc_frame_o, ef);
      check(idx_xor(enc_frame_o) == 0, "R1 zero group parity", idx_xor(enc_frame_o), 0);
    end
    enc_valid_i = 1'b0;

    // R5..R9 exhaustive decode over every frame
    for (int f = 0; f < (1 << FW); f++) begin
      dec_valid_i = 1'b1; dec_frame_i = FW'(f);
      @(negedge clk);
      s  = idx_xor(FW'(f));
      fx = FW'(f);
      if (s == 0) est = 0;
      else if (pw2(s)) est = 1;
      else if (s > FW) est = 3;
      else begin est = 2; fx[s-1] = ~fx[s-1]; end
      ed = pull_data(fx);
      check(dec_valid_o == 1'b1, "R10 dec valid sweep", dec_valid_o, 1);
      check(dec_syndrome_o == PW'(s), "R5 syndrome", dec_syndrome_o, s);
      case (est)
        0: begin
          check(dec_status_o == 2'd0, "R6 status", dec_status_o, 0);
          check(dec_data_o == ed, "R6 data", dec_data_o, ed);
        end
        1: begin
          check(dec_status_o == 2'd1, "R7 status", dec_status_o, 1);
          check(dec_data_o == ed, "R7 data", dec_data_o, ed);
        end
        2: begin
          check(dec_status_o == 2'd2, "R8 status", dec_status_o, 2);
          check(dec_data_o == ed, "R8 data", dec_data_o, ed);
        end
        default: begin
          check(dec_status_o == 2'd3, "R9 status", dec_status_o, 3);
          check(dec_data_o == ed, "R9 data", dec_data_o, ed);
        end
      endcase
    end
    dec_valid_i = 1'b0;
    @(negedge clk);
    check(dec_valid_o == 1'b0, "R10 dec idle end", dec_valid_o, 0);
    check(enc_valid_o == 1'b0, "R3 enc idle end", enc_valid_o, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule